// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block wakes up a fast-page-mode DRAM after power-up and then keeps it refreshed. After reset it holds every strobe inactive for a programmable pause. It then runs a fixed number of warm-up refresh cycles on its own, and only after those does it raise `ready_o`. From then on an interval timer adds one owed refresh each period. The period is chosen so that all 4096 rows are covered within the retention time: about 15.6 µs, or 3120 cycles at 200 MHz.

Owed refreshes collect in a small saturating backlog. While refreshes are owed and no refresh is running, the block holds a request to the access sequencer. Each grant runs one refresh cycle on the strobes. By default the cycle is a column-before-row refresh that uses the device's own row counter, with write enable held high so the device cannot enter its test mode. A parameter selects row-only refresh instead. In that mode the block drives its own 12-bit row counter on the address bus and keeps the column strobe high.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, `ras_n_o`, `cas_n_o` and `we_n_o` are high, `ready_o` and `ref_req_o` are low, and `addr_o` is zero.
- R2: No strobe goes low during the first PAUSE_CYC cycles after reset. In column-before-row mode the column strobe first falls on the cycle after clock edge PAUSE_CYC, counting the first edge after reset release as edge 0. In row-only mode the row strobe first falls T_SET cycles after that.
- R3: After the pause, exactly WARMUP refresh cycles run without any request or grant. `ready_o` rises only after the last of them and never falls again.
- R4: In column-before-row mode the column strobe is low for exactly T_SET cycles before the row strobe falls. It stays low for every cycle in which the row strobe is low. `we_n_o` is high whenever the row strobe falls.
- R5: Each refresh keeps the row strobe low for exactly T_ACT cycles. Between two refreshes the row strobe stays high for at least T_PRE + T_SET cycles.
- R6: Once `ready_o` is high, one owed refresh is added every INTERVAL_CYC cycles.
- R7: `ref_req_o` is high whenever refreshes are owed and none is running, and it stays high until it is granted. A grant seen at a clock edge starts the refresh cycle at that edge.
- R8: The backlog saturates at BACKLOG_MAX. After a long stall with no grant, exactly BACKLOG_MAX refreshes are served before `ref_req_o` drops.
- R9: In row-only mode the column strobe never goes low. `addr_o` holds the row count, which starts at 0 after reset, and stays unchanged while the row strobe is low.
- R10: In row-only mode the row count advances by one after every refresh, warm-up cycles included, and wraps from 4095 to 0.
- R11: A grant while `ref_req_o` is low starts no refresh cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_gnt_i | input | 1 | Grant from the access sequencer |
| ready_o | output | 1 | Initialisation done; normal accesses allowed |
| ref_req_o | output | 1 | Refresh owed, requesting the bus |
| busy_o | output | 1 | Refresh cycle in progress; the block owns the strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low, held high |
| addr_o | output | ROW_W | Row address for row-only refresh, zero otherwise |

## Verification
On every cycle the assertions check these properties:
- the column strobe leads the row strobe and covers it;
- the row address stays still while the row strobe is low;
- the precharge gap is kept;
- the request is held until it is granted;
- the backlog neither wraps nor underflows;
- `ready_o` never falls once set.

Some behaviour can only be shown by the bench scenarios, because it is about counting over long stretches of time:
- the exact pause length and the warm-up count;
- the number of refreshes served after a stall and the refresh rate over ten intervals;
- the full 4096-step walk of the row counter and its wrap back to 0.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SET, PH_ACT, PH_PRE} ref_phase_e;
  typedef enum logic [1:0] {ST_PAUSE, ST_WARM, ST_RUN} init_state_e;
endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int LIMIT = 3120
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dram_ref_backlog.sv
module dram_ref_backlog #(
  parameter int MAX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic nz_o
);
  localparam int CNT_W = $clog2(MAX + 1);

  logic [CNT_W-1:0] cnt_q;

  assign nz_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      case ({inc_i, dec_i})
        2'b10:   if (cnt_q != CNT_W'(MAX)) cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(MAX) && inc_i && !dec_i) |=> (cnt_q == CNT_W'(MAX)));

  p_no_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> nz_o);
endmodule

// File: rtl/dram_ref_strobe.sv
module dram_ref_strobe
  import dram_ref_pkg::*;
#(
  parameter bit ROW_ONLY = 1'b0,
  parameter int ROW_W    = 12,
  parameter int T_SET    = 2,
  parameter int T_ACT    = 12,
  parameter int T_PRE    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic [ROW_W-1:0] addr_o
);
  localparam int T_MAX = (T_ACT > T_PRE) ? ((T_ACT > T_SET) ? T_ACT : T_SET)
                                         : ((T_PRE > T_SET) ? T_PRE : T_SET);
  localparam int CNT_W = $clog2(T_MAX + 1);

  ref_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_cnt;

  always_comb begin
    case (phase_q)
      PH_SET:  last_cnt = (cnt_q == CNT_W'(T_SET - 1));
      PH_ACT:  last_cnt = (cnt_q == CNT_W'(T_ACT - 1));
      PH_PRE:  last_cnt = (cnt_q == CNT_W'(T_PRE - 1));
      default: last_cnt = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_i) begin phase_q <= PH_SET; cnt_q <= '0; end
        PH_SET:  if (last_cnt) begin phase_q <= PH_ACT; cnt_q <= '0; end
                 else cnt_q <= cnt_q + 1'b1;
        PH_ACT:  if (last_cnt) begin phase_q <= PH_PRE; cnt_q <= '0; end
                 else cnt_q <= cnt_q + 1'b1;
        default: if (last_cnt) begin phase_q <= PH_IDLE; cnt_q <= '0; end
                 else cnt_q <= cnt_q + 1'b1;
      endcase
    end
  end

  assign busy_o  = (phase_q != PH_IDLE);
  assign done_o  = (phase_q == PH_PRE) && last_cnt;
  assign ras_n_o = (phase_q != PH_ACT);
  // test mode is entered only with write enable low at the row strobe fall
  assign we_n_o  = 1'b1;

  generate
    if (ROW_ONLY) begin : g_row_only
      logic [ROW_W-1:0] row_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     row_q <= '0;
        else if (done_o) row_q <= row_q + 1'b1;
      end
      assign addr_o  = row_q;
      assign cas_n_o = 1'b1;

      p_addr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ras_n_o && $past(!ras_n_o)) |-> $stable(addr_o));
    end else begin : g_cbr
      assign addr_o  = '0;
      assign cas_n_o = !((phase_q == PH_SET) || (phase_q == PH_ACT));

      p_cas_lead_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));
      p_cas_cover_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ras_n_o |-> !cas_n_o);
    end
  endgenerate

  p_pre_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |=> ras_n_o);
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter bit ROW_ONLY     = 1'b0,
  parameter int ROW_W        = 12,
  parameter int PAUSE_CYC    = 40000,
  parameter int WARMUP       = 8,
  parameter int INTERVAL_CYC = 3120,
  parameter int BACKLOG_MAX  = 8,
  parameter int T_SET        = 2,
  parameter int T_ACT        = 12,
  parameter int T_PRE        = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_gnt_i,
  output logic             ready_o,
  output logic             ref_req_o,
  output logic             busy_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic [ROW_W-1:0] addr_o
);
  localparam int WARM_W = $clog2(WARMUP + 1);

  init_state_e       state_q;
  logic [WARM_W-1:0] warm_q;
  logic              pause_tick, ival_tick, owed, done, start, grant_take;

  dram_ref_timer #(.LIMIT(PAUSE_CYC)) u_pause (
    .clk_i, .rst_ni, .en_i(state_q == ST_PAUSE), .tick_o(pause_tick)
  );

  dram_ref_timer #(.LIMIT(INTERVAL_CYC)) u_interval (
    .clk_i, .rst_ni, .en_i(state_q == ST_RUN), .tick_o(ival_tick)
  );

  dram_ref_backlog #(.MAX(BACKLOG_MAX)) u_backlog (
    .clk_i, .rst_ni, .inc_i(ival_tick), .dec_i(grant_take), .nz_o(owed)
  );

  dram_ref_strobe #(
    .ROW_ONLY(ROW_ONLY), .ROW_W(ROW_W),
    .T_SET(T_SET), .T_ACT(T_ACT), .T_PRE(T_PRE)
  ) u_strobe (
    .clk_i, .rst_ni, .start_i(start), .busy_o, .done_o(done),
    .ras_n_o, .cas_n_o, .we_n_o, .addr_o
  );

  assign ready_o    = (state_q == ST_RUN);
  assign ref_req_o  = ready_o && owed && !busy_o;
  assign grant_take = ref_req_o && ref_gnt_i;
  assign start      = ((state_q == ST_WARM) && !busy_o) || grant_take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PAUSE;
      warm_q  <= '0;
    end else begin
      case (state_q)
        ST_PAUSE: if (pause_tick) state_q <= ST_WARM;
        ST_WARM:  if (done) begin
                    warm_q <= warm_q + 1'b1;
                    if (warm_q == WARM_W'(WARMUP - 1)) state_q <= ST_RUN;
                  end
        default:  state_q <= ST_RUN;
      endcase
    end
  end

  p_quiet_pause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAUSE) |-> (ras_n_o && cas_n_o));

  p_ready_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && !ref_gnt_i) |=> ref_req_o);

  p_req_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_req_o && ready_o && !busy_o) |=> ras_n_o);
endmodule

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;
  localparam int PAUSE = 20;
  localparam int WARM  = 8;
  localparam int TS = 2, TA = 4, TP = 3;
  localparam int IVC = 200;
  localparam int IVR = 12;
  localparam int BMAX = 8;

  logic clk = 1'b0, rst_n = 1'b0, gnt_c = 1'b0;
  logic c_ready, c_req, c_busy, c_ras, c_cas, c_we;
  logic r_ready, r_req, r_busy, r_ras, r_cas, r_we;
  logic [11:0] c_addr, r_addr;
  int vectors = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  dram_refresh_sched #(.ROW_ONLY(1'b0), .PAUSE_CYC(PAUSE), .WARMUP(WARM),
    .INTERVAL_CYC(IVC), .BACKLOG_MAX(BMAX), .T_SET(TS), .T_ACT(TA), .T_PRE(TP))
  u_dram_refresh_sched (.clk_i(clk), .rst_ni(rst_n), .ref_gnt_i(gnt_c),
    .ready_o(c_ready), .ref_req_o(c_req), .busy_o(c_busy), .ras_n_o(c_ras),
    .cas_n_o(c_cas), .we_n_o(c_we), .addr_o(c_addr));

  dram_refresh_sched #(.ROW_ONLY(1'b1), .PAUSE_CYC(PAUSE), .WARMUP(WARM),
    .INTERVAL_CYC(IVR), .BACKLOG_MAX(BMAX), .T_SET(TS), .T_ACT(TA), .T_PRE(TP))
  u_dram_refresh_sched_ro (.clk_i(clk), .rst_ni(rst_n), .ref_gnt_i(1'b1),
    .ready_o(r_ready), .ref_req_o(r_req), .busy_o(r_busy), .ras_n_o(r_ras),
    .cas_n_o(r_cas), .we_n_o(r_we), .addr_o(r_addr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // column-before-row monitor
  bit c_ras_q = 1'b1, c_seen = 1'b0, c_rdy_q = 1'b0;
  int c_cas_run = 0, c_lo_run = 0, c_hi_run = 0, c_falls = 0, c_warm = 0;
  always @(negedge clk) if (rst_n) begin
    if (!c_seen && !c_cas) begin
      c_seen = 1'b1;
      chk(cyc == PAUSE + 1, "R2 cbr first strobe", cyc, PAUSE + 1);
    end
    if (c_ras_q && !c_ras) begin
      c_falls++;
      if (!c_ready) c_warm++;
      chk(c_cas_run == TS, "R4 cas lead", c_cas_run, TS);
      chk(c_we == 1'b1, "R4 we high", c_we, 1);
      if (c_falls > 1) chk(c_hi_run >= TP + TS, "R5 precharge gap", c_hi_run, TP + TS);
    end
    if (!c_ras) chk(!c_cas, "R4 cas cover", c_cas, 0);
    if (!c_ras_q && c_ras) chk(c_lo_run == TA, "R5 ras width", c_lo_run, TA);
    if (!c_rdy_q && c_ready) chk(c_warm == WARM, "R3 warm-up count", c_warm, WARM);
    if (c_rdy_q) chk(c_ready, "R3 ready sticky", c_ready, 1);
    c_cas_run = (!c_cas && c_ras) ? c_cas_run + 1 : 0;
    c_lo_run  = !c_ras ? c_lo_run + 1 : 0;
    c_hi_run  = c_ras ? c_hi_run + 1 : 0;
    c_ras_q   = c_ras;
    c_rdy_q   = c_ready;
  end

  // row-only monitor
  bit r_ras_q = 1'b1, r_rdy_q = 1'b0;
  int r_falls = 0, r_warm = 0, r_lo_run = 0;
  logic [11:0] r_addr_q = '0;
  always @(negedge clk) if (rst_n) begin
    if (r_cas !== 1'b1) chk(1'b0, "R9 cas held high", r_cas, 1);
    if (r_ras_q && !r_ras) begin
      if (r_falls == 0) chk(cyc == PAUSE + 1 + TS, "R2 row-only first strobe", cyc, PAUSE + 1 + TS);
      if (!r_ready) r_warm++;
      if (r_falls == 4096) chk(r_addr == 12'd0, "R10 row wrap", r_addr, 0);
      else if (r_falls % 512 == 0)
        chk(r_addr == r_falls[11:0], "R10 row step", r_addr, r_falls % 4096);
      else if (r_addr != r_falls[11:0])
        chk(1'b0, "R9 row address", r_addr, r_falls % 4096);
      r_falls++;
    end
    if (!r_ras && !r_ras_q && r_addr != r_addr_q)
      chk(1'b0, "R9 address stable", r_addr, r_addr_q);
    if (!r_ras_q && r_ras) chk(r_lo_run == TA, "R5 row-only ras width", r_lo_run, TA);
    if (!r_rdy_q && r_ready) chk(r_warm == WARM, "R3 row-only warm-up", r_warm, WARM);
    r_lo_run = !r_ras ? r_lo_run + 1 : 0;
    r_ras_q  = r_ras;
    r_rdy_q  = r_ready;
    r_addr_q = r_addr;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    chk(c_ras && c_cas && c_we && r_ras && r_cas && r_we, "R1 strobes idle", 0, 1);
    chk(!c_ready && !r_ready && !c_req && !r_req, "R1 flags low", 1, 0);
    chk(c_addr == 0 && r_addr == 0, "R1 address", r_addr, 0);
    rst_n = 1'b1;
    wait (c_ready);
    @(negedge clk);
    repeat (2 * IVC + 20) @(negedge clk);
    chk(c_req, "R7 request raised", c_req, 1);
    repeat (10 * IVC) @(negedge clk);
    chk(c_req, "R7 request held", c_req, 1);
    chk(c_cas && c_ras, "R11 no grant no cycle", c_cas, 1);
    gnt_c = 1'b1;
    f0 = c_falls;
    @(negedge clk);
    chk(!c_cas, "R7 grant starts cycle", c_cas, 0);
    repeat (100) @(negedge clk);
    chk(c_falls - f0 == BMAX, "R8 saturated backlog served", c_falls - f0, BMAX);
    chk(!c_req, "R7 request drops when drained", c_req, 0);
    f0 = c_falls;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(c_cas && c_ras && !c_req, "R11 grant without request", c_cas, 1);
    end
    repeat (10 * IVC) @(negedge clk);
    chk(c_falls - f0 == 10, "R6 refresh rate", c_falls - f0, 10);
    wait (r_falls >= 4100);
    repeat (20) @(negedge clk);
    chk(r_falls >= 4100, "R10 row walk", r_falls, 4100);
    finish_run();
  end
endmodule